// File: doc/BRIEF.md
# Two-wire serial EEPROM target

This block is a target (slave) on a two-wire serial bus that fronts a small byte-wide register file standing in for EEPROM storage. It oversamples the clock and data lines on a fast system clock, finds start and stop conditions, and checks the device-address byte against three strap pins. It then takes a word address and either collects write bytes or streams read bytes back. It drives the data line open-drain through an output enable that pulls the line low.

Writes go into an internal page buffer and reach the array only when a stop ends the write. A programmable busy window follows the stop. While that window is open, the target refuses its own address. A write-protect input keeps the array from being changed, and reads continue to work while it is set. The block covers the 128-byte and 256-byte densities, both with 8-byte pages.

Top module: `eeprom_2w_target`

## Requirements
- R1: A high-to-low data transition while the clock is high (start) restarts the address phase from any state. A low-to-high data transition while the clock is high (stop) returns the target to standby with SDA released. After reset SDA is released.
- R2: The first byte after a start is sent MSB first and holds 4'b1010, then three bits that must equal the address pins, then a read/write bit (1 = read). On a match the target pulls SDA low for the whole ninth clock.
- R3: The target changes its SDA drive only after a falling clock edge, a start or a stop. It acknowledges each received word-address byte and write-data byte by pulling SDA low in the ninth clock.
- R4: Write-data bytes are held back until a stop. A repeated start before the stop discards them. After the stop they are stored in the array.
- R5: In a multi-byte write, the three low address bits wrap within the current 8-byte page and the upper bits stay unchanged.
- R6: A random read returns the byte at the requested address, MSB first, one bit per clock-low period. A random read is a write of the word address, then a repeated start, then a read address.
- R7: In a read, a controller acknowledge (SDA low in the ninth clock) moves to the next address, and the address wraps from the last byte to byte 0. A controller non-acknowledge followed by a stop ends the read with SDA released.
- R8: When the write-protect input is high as a data byte completes, that byte is acknowledged but not stored, and no busy window starts. Reads are unaffected.
- R9: A stop that stores data starts a busy window of WR_BUSY_CYCLES system clocks. During the window the device address is not acknowledged. After the window it is acknowledged again.
- R10: A device-address byte that does not match gets no acknowledge. The target then leaves SDA released for the rest of that transfer until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| dev_pins_i | input | 3 | Strap pins compared with the device-address bits |
| wp_i | input | 1 | Write protect, high blocks array updates |
| sda_oe_o | output | 1 | High pulls the data line low (open-drain enable) |

## Verification
Two conditions are hard to reach from the ports. The first is a device address that arrives while the busy window is still open. The bench sets the window long enough that a start and address sent right after a write's stop land inside it, then waits past the window and addresses the target again. The second is data that was collected but never committed. The bench ends a write with a repeated start instead of a stop and reads the location back. A whole-array wrap is covered by a sequential read started just below the top address. Write protect is exercised with a multi-byte write that must be acknowledged and leave no trace.

// File: rtl/eep_pkg.sv
// Shared constants and types for the two-wire EEPROM target.
// Assumes: the device-type nibble is fixed for every density.
package eep_pkg;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEVADDR,
        S_ACK_DEV,
        S_WORDADDR,
        S_ACK_WA,
        S_WR_DATA,
        S_ACK_WR,
        S_RD_DATA,
        S_RD_ACK,
        S_IGNORE
    } tgt_state_e;
endpackage

// File: rtl/eep_bus_sync.sv
// Synchronises the bus lines into the system clock domain and flags
// clock edges, start and stop conditions as one-cycle pulses.
// Assumes: system clock is many times faster than the bus clock; STAGES >= 2.
module eep_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    // Shift both lines through the synchroniser chain; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // Keep the previous synchronised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

    p_one_event_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall, start_ev, stop_ev}));
endmodule

// File: rtl/eep_busy_timer.sv
// Counts the internal write-busy window after a committing stop.
// Assumes: load is a single-cycle pulse; CYCLES >= 1.
module eep_busy_timer #(
    parameter int CYCLES = 625000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain;

    // Reload on commit, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= CW'(CYCLES);
        end else if (remain != '0) begin
            remain <= remain - CW'(1);
        end
    end

    assign busy = (remain != '0);

    p_busy_from_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(load));
endmodule

// File: rtl/eep_array.sv
// Byte-wide register file standing in for the non-volatile array.
// A commit writes every valid page-buffer byte into one page at once.
// Assumes: MEM_BYTES and PAGE_BYTES are powers of two, PAGE_BYTES >= 2.
module eep_array #(
    parameter int MEM_BYTES  = 256,
    parameter int PAGE_BYTES = 8,
    localparam int AW = $clog2(MEM_BYTES),
    localparam int PW = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           rd_addr,
    output logic [7:0]              rd_data,
    input  logic                    commit,
    input  logic [AW-PW-1:0]        commit_page,
    input  logic [PAGE_BYTES*8-1:0] wr_bytes,
    input  logic [PAGE_BYTES-1:0]   wr_valid
);
    logic [7:0] mem [MEM_BYTES];

    // Clear on reset; on commit store each valid byte of the page buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
        end else if (commit) begin
            for (int k = 0; k < PAGE_BYTES; k++) begin
                if (wr_valid[k]) mem[{commit_page, k[PW-1:0]}] <= wr_bytes[k*8 +: 8];
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eep_ctrl.sv
// Protocol engine of the target: address match, word address, page
// buffering of write data, read streaming and acknowledge control.
// Assumes: bus events arrive as exclusive one-cycle pulses.
module eep_ctrl
    import eep_pkg::*;
#(
    parameter int MEM_BYTES  = 256,
    parameter int PAGE_BYTES = 8,
    localparam int AW = $clog2(MEM_BYTES),
    localparam int PW = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sda_s,
    input  logic                    scl_rise,
    input  logic                    scl_fall,
    input  logic                    start_ev,
    input  logic                    stop_ev,
    input  logic [2:0]              pins_i,
    input  logic                    wp_i,
    input  logic                    busy_i,
    input  logic [7:0]              rd_data_i,
    output logic [AW-1:0]           mem_addr_o,
    output logic                    commit_o,
    output logic [PAGE_BYTES*8-1:0] wr_bytes_o,
    output logic [PAGE_BYTES-1:0]   wr_valid_o,
    output logic                    sda_oe_o
);
    localparam logic [AW-1:0] ADDR_ONE = AW'(1);
    localparam logic [PW-1:0] OFF_ONE  = PW'(1);

    tgt_state_e          state;
    logic [3:0]          cnt;
    logic [7:0]          shreg;
    logic [AW-1:0]       addr;
    logic                rw;
    logic                nack;
    logic [7:0]          rbyte;
    logic                oe;
    logic [7:0]          pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvalid;
    logic                commit;

    // Main protocol sequencer, advanced by bus events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            addr   <= '0;
            rw     <= 1'b0;
            nack   <= 1'b0;
            rbyte  <= '0;
            oe     <= 1'b0;
            pvalid <= '0;
            commit <= 1'b0;
            for (int k = 0; k < PAGE_BYTES; k++) pbuf[k] <= '0;
        end else begin
            commit <= 1'b0;
            if (start_ev) begin
                state  <= S_DEVADDR;
                cnt    <= '0;
                oe     <= 1'b0;
                pvalid <= '0;
            end else if (stop_ev) begin
                state <= S_IDLE;
                oe    <= 1'b0;
                if ((state == S_WR_DATA || state == S_ACK_WR) && (|pvalid)) commit <= 1'b1;
            end else begin
                case (state)
                    S_DEVADDR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_s};
                            cnt   <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            if (shreg[7:1] == {DEV_TYPE, pins_i} && !busy_i) begin
                                oe    <= 1'b1;
                                rw    <= shreg[0];
                                state <= S_ACK_DEV;
                            end else begin
                                state <= S_IGNORE;
                            end
                        end
                    end
                    S_ACK_DEV: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                rbyte <= rd_data_i;
                                oe    <= ~rd_data_i[7];
                                addr  <= addr + ADDR_ONE;
                                state <= S_RD_DATA;
                            end else begin
                                oe    <= 1'b0;
                                state <= S_WORDADDR;
                            end
                        end
                    end
                    S_WORDADDR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_s};
                            cnt   <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            addr  <= shreg[AW-1:0];
                            oe    <= 1'b1;
                            state <= S_ACK_WA;
                        end
                    end
                    S_ACK_WA, S_ACK_WR: begin
                        if (scl_fall) begin
                            oe    <= 1'b0;
                            cnt   <= '0;
                            state <= S_WR_DATA;
                        end
                    end
                    S_WR_DATA: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_s};
                            cnt   <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            if (!wp_i) begin
                                pbuf[addr[PW-1:0]]   <= shreg;
                                pvalid[addr[PW-1:0]] <= 1'b1;
                            end
                            addr  <= {addr[AW-1:PW], addr[PW-1:0] + OFF_ONE};
                            oe    <= 1'b1;
                            state <= S_ACK_WR;
                        end
                    end
                    S_RD_DATA: begin
                        if (scl_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (cnt == 4'd8) begin
                                oe    <= 1'b0;
                                state <= S_RD_ACK;
                            end else begin
                                oe <= ~rbyte[3'd7 - cnt[2:0]];
                            end
                        end
                    end
                    S_RD_ACK: begin
                        if (scl_rise) begin
                            nack <= sda_s;
                        end else if (scl_fall) begin
                            if (!nack) begin
                                rbyte <= rd_data_i;
                                oe    <= ~rd_data_i[7];
                                addr  <= addr + ADDR_ONE;
                                cnt   <= '0;
                                state <= S_RD_DATA;
                            end else begin
                                state <= S_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Flatten the page buffer for the array's commit port.
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
        assign wr_bytes_o[g*8 +: 8] = pbuf[g];
    end

    assign wr_valid_o = pvalid;
    assign commit_o   = commit;
    assign mem_addr_o = addr;
    assign sda_oe_o   = oe;

    p_drive_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (oe != $past(oe)) |-> $past(scl_fall || start_ev || stop_ev));
    p_ack_needs_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACK_DEV) |-> (shreg[7:1] == {DEV_TYPE, pins_i}));
    p_no_ack_when_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACK_DEV && $past(state) != S_ACK_DEV) |-> !$past(busy_i));
    p_commit_on_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(stop_ev));
    p_ignore_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IGNORE) |-> !oe);
    p_page_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACK_WR) |-> (addr[AW-1:PW] == $past(addr[AW-1:PW])));
    p_wp_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACK_WR && $past(state) == S_WR_DATA && $past(wp_i)) |-> (pvalid == $past(pvalid)));
    p_stop_releases_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_ev) |-> !oe);
endmodule

// File: rtl/eeprom_2w_target.sv
// Top of the two-wire EEPROM target: bus synchroniser, protocol engine,
// register-file array and write-busy timer.
// Assumes: an external pull-up on the data line; sda_oe_o high pulls it low.
module eeprom_2w_target #(
    parameter int MEM_BYTES      = 256,
    parameter int PAGE_BYTES     = 8,
    parameter int WR_BUSY_CYCLES = 625000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] dev_pins_i,
    input  logic       wp_i,
    output logic       sda_oe_o
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);

    logic                    sda_s;
    logic                    scl_rise;
    logic                    scl_fall;
    logic                    start_ev;
    logic                    stop_ev;
    logic                    busy;
    logic [7:0]              rd_data;
    logic [AW-1:0]           mem_addr;
    logic                    commit;
    logic [PAGE_BYTES*8-1:0] wr_bytes;
    logic [PAGE_BYTES-1:0]   wr_valid;

    eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    eep_ctrl #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_ev   (start_ev),
        .stop_ev    (stop_ev),
        .pins_i     (dev_pins_i),
        .wp_i       (wp_i),
        .busy_i     (busy),
        .rd_data_i  (rd_data),
        .mem_addr_o (mem_addr),
        .commit_o   (commit),
        .wr_bytes_o (wr_bytes),
        .wr_valid_o (wr_valid),
        .sda_oe_o   (sda_oe_o)
    );

    eep_array #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_addr     (mem_addr),
        .rd_data     (rd_data),
        .commit      (commit),
        .commit_page (mem_addr[AW-1:PW]),
        .wr_bytes    (wr_bytes),
        .wr_valid    (wr_valid)
    );

    eep_busy_timer #(.CYCLES(WR_BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (commit),
        .busy  (busy)
    );
endmodule

// File: tb/eeprom_2w_target_tb_top.sv
// Bench: acts as bus controller, keeps a behavioural byte model of the
// array and checks acknowledges, read data and SDA release every clock.
module eeprom_2w_target_tb_top;
    localparam int BUSY = 1000;
    localparam int Q    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic wp = 1'b0;
    logic [2:0] pins = 3'b101;
    logic sda_oe;
    logic sda_line;

    always #4 clk = ~clk;
    assign sda_line = sda_drv & ~sda_oe;

    eeprom_2w_target #(.WR_BUSY_CYCLES(BUSY)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_drv),
        .sda_i      (sda_line),
        .dev_pins_i (pins),
        .wp_i       (wp),
        .sda_oe_o   (sda_oe)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] ref_mem [256];
    logic [7:0] wq [$];
    bit quiet_chk = 1'b0;
    string quiet_req = "R3";

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock model: while the controller owns a bit, the target must be silent.
    always @(negedge clk) if (quiet_chk) chk(quiet_req, int'(sda_oe), 0);

    task automatic q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; q();
        scl_drv = 1'b1; q();
        sda_drv = 1'b0; q();
        scl_drv = 1'b0; q();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; q();
        scl_drv = 1'b1; q();
        sda_drv = 1'b1; q();
    endtask

    task automatic send_byte(input logic [7:0] b, input string req, output bit acked);
        quiet_req = req;
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; q();
            quiet_chk = 1'b1;
            scl_drv = 1'b1; q(); q();
            scl_drv = 1'b0; quiet_chk = 1'b0; q();
        end
        sda_drv = 1'b1; q();
        scl_drv = 1'b1; q();
        acked = !sda_line; q();
        scl_drv = 1'b0; q();
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] b);
        sda_drv = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            q();
            scl_drv = 1'b1; q();
            b[i] = sda_line; q();
            scl_drv = 1'b0;
        end
        q();
        sda_drv = nack; q();
        scl_drv = 1'b1; q(); q();
        scl_drv = 1'b0; q();
        sda_drv = 1'b1;
    endtask

    task automatic dev_addr(input bit rd, input logic [2:0] p, input bit exp_ack, input string req);
        bit a;
        send_byte({4'b1010, p, rd}, req, a);
        chk(req, int'(a), int'(exp_ack));
    endtask

    task automatic write_tx(input logic [7:0] a, input bit do_stop);
        bit ack;
        bus_start();
        dev_addr(1'b0, pins, 1'b1, "R2");
        send_byte(a, "R3", ack);
        chk("R3", int'(ack), 1);
        foreach (wq[k]) begin
            send_byte(wq[k], "R3", ack);
            chk("R3", int'(ack), 1);
            if (do_stop && !wp) ref_mem[{a[7:3], 3'(a[2:0] + 3'(k))}] = wq[k];
        end
        if (do_stop) bus_stop();
    endtask

    task automatic read_tx(input logic [7:0] a, input int n, input string req);
        bit ack;
        logic [7:0] b;
        bus_start();
        dev_addr(1'b0, pins, 1'b1, "R2");
        send_byte(a, "R3", ack);
        chk("R3", int'(ack), 1);
        bus_start();
        dev_addr(1'b1, pins, 1'b1, "R2");
        for (int k = 0; k < n; k++) begin
            recv_byte(k == n - 1, b);
            chk(req, int'(b), int'(ref_mem[8'(a + 8'(k))]));
        end
        bus_stop();
        chk("R1", int'(sda_oe), 0);
    endtask

    task automatic wait_busy();
        repeat (BUSY + 40) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit ack;
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        chk("R1", int'(sda_oe), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R4: data ended by a repeated start must not be stored
        wq = '{8'hA5};
        write_tx(8'h10, 1'b0);
        read_tx(8'h10, 1, "R4");

        // R4/R9/R6: stored after stop, busy refuses address, random read afterwards
        write_tx(8'h10, 1'b1);
        bus_start();
        dev_addr(1'b0, pins, 1'b0, "R9");
        bus_stop();
        wait_busy();
        bus_start();
        dev_addr(1'b0, pins, 1'b1, "R9");
        bus_stop();
        read_tx(8'h10, 1, "R6");

        // R10: wrong pins, no acknowledge and silence until the next start
        bus_start();
        dev_addr(1'b0, 3'b001, 1'b0, "R10");
        send_byte(8'h10, "R10", ack);
        chk("R10", int'(ack), 0);
        send_byte(8'hFF, "R10", ack);
        chk("R10", int'(ack), 0);
        bus_stop();
        read_tx(8'h10, 1, "R10");

        // R5: four bytes from offset 6 wrap to offset 0 of the same page
        wq = '{8'h11, 8'h22, 8'h33, 8'h44};
        write_tx(8'h1E, 1'b1);
        wait_busy();
        read_tx(8'h18, 8, "R5");

        // R7: sequential read across the top of the array
        wq = '{8'h77, 8'h88};
        write_tx(8'hFE, 1'b1);
        wait_busy();
        wq = '{8'h99};
        write_tx(8'h00, 1'b1);
        wait_busy();
        read_tx(8'hFD, 4, "R7");

        // R8: protected write is acknowledged, not stored, no busy window
        wp = 1'b1;
        wq = '{8'h5A, 8'h6B};
        write_tx(8'h10, 1'b1);
        read_tx(8'h10, 2, "R8");
        wp = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule